// File: doc/BRIEF.md
# Sorting Interrupt Controller

This block gathers level-sensitive interrupt requests from a parameterised number of sources. The sources are grouped in banks of 32, with three banks (96 sources) by default and four banks (128 sources) as the larger setting. Each source has a mask bit, and every source starts masked. Software can change the mask through three registers per bank: a plain write register, an alias that clears the bits written as 1, and an alias that sets the bits written as 1. A per-bank pending register shows which sources are both active and unmasked.

When the sorter is idle and at least one unmasked source is active, it starts a sorting pass that lasts a fixed number of cycles. At the end of the pass, the number of the lowest active unmasked source is placed in the sorted-result register, and the interrupt line is raised. The pass is marked spurious if either of two things happens during the window: the chosen source stops being pending, or a mask write changes the mask. The interrupt line and the result then stay fixed until software writes the acknowledge bit. After the acknowledge, the sorter returns to idle and can start the next pass.

The block also has a soft reset with a completion flag, a read-only revision word, and two plain storage registers: a protection enable and a threshold.

Top module: `sort_intc`

## Requirements
- R1: After hardware reset, every mask bit is 1 and the interrupt line is low. The sorted-result register (0x40) reads 0xFFFFFF80, and bit 0 of the status register (0x14) reads 1.
- R2: Each bank b has three mask registers. The mask register at 0x84+0x20·b loads the written word. Writing a 1 to a bit at 0x88+0x20·b clears that mask bit, and writing a 1 to a bit at 0x8C+0x20·b sets it. A 0 bit written to either alias leaves the mask bit unchanged, and other banks are not affected.
- R3: The pending register at 0x98+0x20·b reads source level AND NOT mask for the 32 sources of bank b.
- R4: A pass starts on the first clock edge at which the sorter is idle and some source is active and unmasked. The result is latched SORT_CYCLES (10) edges later. At that point, bits 6:0 of 0x40 hold the winning source number, bits 31:7 are 0, and the interrupt line goes high.
- R5: When several sources are active and unmasked, the lowest source number wins.
- R6: If the chosen source stops being pending at any time during the pass, the result reads 0xFFFFFF80 (spurious), even if the source comes back before the pass ends.
- R7: A mask write during the pass that changes any mask bit makes the result spurious. A mask write that leaves the mask unchanged does not.
- R8: While a result is held, the interrupt line stays high and the result does not change. A write of 1 to bit 0 of 0x48 releases the result. A write with bit 0 equal to 0 is ignored, and so is an acknowledge written during a pass.
- R9: After the acknowledge, a new pass starts if a source is still active and unmasked.
- R10: Writing a 1 to bit 1 of 0x10 starts a soft reset. Status bit 0 reads 0 on the next cycle and reads 1 one cycle later. By then all masks are set, the sorter is idle, the interrupt line is low, the result reads 0xFFFFFF80, and the protection register reads 0.
- R11: The register at 0x00 reads the major revision in bits 7:4 and the minor revision in bits 3:0, with all other bits 0.
- R12: The following register bits read back the last value written: bit 0 of 0x10, bit 0 of 0x4C (protection enable), and bits 7:0 of 0x68 (threshold). All higher bits of these registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 12 | Register byte address |
| busWe | input | 1 | Write strobe, one cycle per write |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| srcLevel | input | 32·NUM_BANKS | Level of each interrupt source |
| irqOut | output | 1 | High while a sort result awaits acknowledge |

## Verification
The bench targets the edges of the sorting window. It checks the exact edge at which the result appears, a winner that drops out and comes back within the window, and a mask write in the middle of a pass. A design that sampled only at the end of the pass would return a valid number where a spurious one is required. A design that compared mask writes by address rather than by effect would flag a harmless write to an already-masked bit.

The bench also sends acknowledges while a pass is running and while a result is held. A sorter that re-arms early would replace a result the processor has not yet read. A sweep over every source, and over pairs of sources, exposes wrong bank decoding and wrong priority order. The soft-reset sequence checks that the completion flag really drops for a cycle.

// File: rtl/sort_intc_pkg.sv
package sort_intc_pkg;

  // Register byte addresses outside the banked region
  localparam logic [11:0] OFF_REV  = 12'h000;
  localparam logic [11:0] OFF_CFG  = 12'h010;
  localparam logic [11:0] OFF_STAT = 12'h014;
  localparam logic [11:0] OFF_SIR  = 12'h040;
  localparam logic [11:0] OFF_CTRL = 12'h048;
  localparam logic [11:0] OFF_PROT = 12'h04C;
  localparam logic [11:0] OFF_THR  = 12'h068;

  // Banked region: bank b occupies addr[11:5] == BANK_BASE + b
  localparam logic [6:0] BANK_BASE = 7'h04;
  localparam logic [4:0] BOFF_MASK = 5'h04;
  localparam logic [4:0] BOFF_CLR  = 5'h08;
  localparam logic [4:0] BOFF_SET  = 5'h0C;
  localparam logic [4:0] BOFF_PEND = 5'h18;

  localparam int unsigned IDX_W = 7;
  localparam logic [31:0] SPUR_WORD = 32'hFFFF_FF80;

  typedef enum logic [1:0] {SORT_IDLE, SORT_RUN, SORT_HOLD} sortState_t;

  typedef struct packed {
    logic startSort;   // idle and something pending: latch candidate
    logic inSort;      // pass window open
    logic finishSort;  // last cycle of the pass: latch result
    logic clearAll;    // soft reset clear
  } sortStrb_t;

endpackage

// File: rtl/sort_intc_ctrl.sv
module sort_intc_ctrl
  import sort_intc_pkg::*;
#(
  parameter int unsigned SORT_CYCLES = 10
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      anyPend,
  input  logic      ackWr,
  input  logic      softWr,
  output sortStrb_t strb,
  output logic      holding,
  output logic      resetDone
);

  localparam int unsigned CNT_W = $clog2(SORT_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SORT_CYCLES);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  sortState_t state;
  logic [CNT_W-1:0] cnt;
  logic rstPend;

  always_comb begin
    strb.clearAll   = rstPend;
    strb.startSort  = (state == SORT_IDLE) && anyPend && !rstPend;
    strb.inSort     = (state == SORT_RUN);
    strb.finishSort = (state == SORT_RUN) && (cnt == CNT_LAST) && !rstPend;
    holding         = (state == SORT_HOLD);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= SORT_IDLE;
      cnt       <= '0;
      rstPend   <= 1'b0;
      resetDone <= 1'b1;
    end else begin
      rstPend <= softWr;
      if (softWr)       resetDone <= 1'b0;
      else if (rstPend) resetDone <= 1'b1;

      if (rstPend) begin
        state <= SORT_IDLE;
        cnt   <= '0;
      end else begin
        case (state)
          SORT_IDLE: if (anyPend) begin
            state <= SORT_RUN;
            cnt   <= CNT_ONE;
          end
          SORT_RUN: if (cnt == CNT_LAST) begin
            state <= SORT_HOLD;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CNT_ONE;
          end
          SORT_HOLD: if (ackWr) state <= SORT_IDLE;
          default: state <= SORT_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/sort_intc_dp.sv
module sort_intc_dp
  import sort_intc_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 3,
  parameter logic [3:0]  REV_MAJOR = 4'h5,
  parameter logic [3:0]  REV_MINOR = 4'h0
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [11:0]               busAddr,
  input  logic                      busWe,
  input  logic [31:0]               busWdata,
  output logic [31:0]               busRdata,
  input  logic [32*NUM_BANKS-1:0]   srcLevel,
  input  sortStrb_t                 strb,
  input  logic                      resetDone,
  output logic                      anyPend,
  output logic                      ackWr,
  output logic                      softWr,
  output logic [32*NUM_BANKS-1:0]   maskVec,
  output logic [31:0]               sirWord
);

  localparam int unsigned NUM_SRC = 32 * NUM_BANKS;

  logic [NUM_SRC-1:0] maskNext;
  logic [NUM_SRC-1:0] pendVec;
  logic [IDX_W-1:0]   winIdx;
  logic [IDX_W-1:0]   candIdx;
  logic               maskChg;
  logic               dropNow;
  logic               spurFlag;
  logic               cfgIdle;
  logic               protEn;
  logic [7:0]         thrReg;

  assign pendVec = srcLevel & ~maskVec;
  assign anyPend = |pendVec;
  assign ackWr   = busWe && (busAddr == OFF_CTRL) && busWdata[0];
  assign softWr  = busWe && (busAddr == OFF_CFG) && busWdata[1];
  assign dropNow = !pendVec[candIdx];
  assign maskChg = (maskNext != maskVec);

  // Next mask from the three per-bank write paths
  always_comb begin
    maskNext = maskVec;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (busWe && (busAddr[11:5] == BANK_BASE + 7'(b))) begin
        case (busAddr[4:0])
          BOFF_MASK: maskNext[b*32 +: 32] = busWdata;
          BOFF_CLR:  maskNext[b*32 +: 32] = maskVec[b*32 +: 32] & ~busWdata;
          BOFF_SET:  maskNext[b*32 +: 32] = maskVec[b*32 +: 32] | busWdata;
          default: ;
        endcase
      end
    end
  end

  // Lowest-numbered pending source
  always_comb begin
    winIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pendVec[i]) winIdx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskVec  <= '1;
      candIdx  <= '0;
      spurFlag <= 1'b0;
      sirWord  <= SPUR_WORD;
      cfgIdle  <= 1'b0;
      protEn   <= 1'b0;
      thrReg   <= '0;
    end else if (strb.clearAll) begin
      maskVec  <= '1;
      candIdx  <= '0;
      spurFlag <= 1'b0;
      sirWord  <= SPUR_WORD;
      cfgIdle  <= 1'b0;
      protEn   <= 1'b0;
      thrReg   <= '0;
    end else begin
      maskVec <= maskNext;
      if (busWe && busAddr == OFF_CFG)  cfgIdle <= busWdata[0];
      if (busWe && busAddr == OFF_PROT) protEn  <= busWdata[0];
      if (busWe && busAddr == OFF_THR)  thrReg  <= busWdata[7:0];

      if (strb.startSort) begin
        candIdx  <= winIdx;
        spurFlag <= 1'b0;
      end else if (strb.inSort && (dropNow || maskChg)) begin
        spurFlag <= 1'b1;
      end

      if (strb.finishSort) begin
        sirWord <= (spurFlag || dropNow || maskChg) ? SPUR_WORD
                                                    : {{(32-IDX_W){1'b0}}, candIdx};
      end
    end
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      OFF_REV:  busRdata = {24'b0, REV_MAJOR, REV_MINOR};
      OFF_CFG:  busRdata = {31'b0, cfgIdle};
      OFF_STAT: busRdata = {31'b0, resetDone};
      OFF_SIR:  busRdata = sirWord;
      OFF_PROT: busRdata = {31'b0, protEn};
      OFF_THR:  busRdata = {24'b0, thrReg};
      default: begin
        for (int b = 0; b < NUM_BANKS; b++) begin
          if (busAddr[11:5] == BANK_BASE + 7'(b)) begin
            if (busAddr[4:0] == BOFF_MASK) busRdata = maskVec[b*32 +: 32];
            if (busAddr[4:0] == BOFF_PEND) busRdata = pendVec[b*32 +: 32];
          end
        end
      end
    endcase
  end

endmodule

// File: rtl/sort_intc.sv
module sort_intc
  import sort_intc_pkg::*;
#(
  parameter int unsigned NUM_BANKS   = 3,
  parameter int unsigned SORT_CYCLES = 10,
  parameter logic [3:0]  REV_MAJOR   = 4'h5,
  parameter logic [3:0]  REV_MINOR   = 4'h0
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [11:0]             busAddr,
  input  logic                    busWe,
  input  logic [31:0]             busWdata,
  output logic [31:0]             busRdata,
  input  logic [32*NUM_BANKS-1:0] srcLevel,
  output logic                    irqOut
);

  localparam int unsigned NUM_SRC = 32 * NUM_BANKS;

  sortStrb_t          strb;
  logic               holding;
  logic               resetDone;
  logic               anyPend;
  logic               ackWr;
  logic               softWr;
  logic [NUM_SRC-1:0] maskVec;
  logic [31:0]        sirWord;

  sort_intc_ctrl #(.SORT_CYCLES(SORT_CYCLES)) ctrl_i (
    .clk(clk), .rstN(rstN), .anyPend(anyPend), .ackWr(ackWr), .softWr(softWr),
    .strb(strb), .holding(holding), .resetDone(resetDone)
  );

  sort_intc_dp #(.NUM_BANKS(NUM_BANKS), .REV_MAJOR(REV_MAJOR), .REV_MINOR(REV_MINOR)) dp_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
    .busRdata(busRdata), .srcLevel(srcLevel), .strb(strb), .resetDone(resetDone),
    .anyPend(anyPend), .ackWr(ackWr), .softWr(softWr), .maskVec(maskVec), .sirWord(sirWord)
  );

  assign irqOut = holding;

endmodule

// File: rtl/sort_intc_chk.sv
module sort_intc_chk
  import sort_intc_pkg::*;
#(
  parameter int unsigned NUM_SRC     = 96,
  parameter int unsigned SORT_CYCLES = 10
) (
  input logic               clk,
  input logic               rstN,
  input logic               irqOut,
  input logic               ackWr,
  input logic               softWr,
  input sortStrb_t          strb,
  input logic [NUM_SRC-1:0] maskVec,
  input logic [31:0]        sirWord
);

  logic [15:0] runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) runLen <= '0;
    else       runLen <= strb.inSort ? runLen + 16'd1 : 16'd0;
  end

  assert_sort_len_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.finishSort |-> runLen == 16'(SORT_CYCLES - 1));

  assert_window_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.inSort |-> runLen < 16'(SORT_CYCLES));

  assert_irq_from_sort_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past(strb.finishSort));

  assert_hold_until_ack_R8: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !ackWr && !softWr && !strb.clearAll) |=> irqOut);

  assert_result_stable_R8: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !strb.clearAll) |=> $stable(sirWord));

  assert_masked_after_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearAll |=> (maskVec == '1 && !irqOut));

  assert_result_format_R6: assert property (@(posedge clk) disable iff (!rstN)
    (sirWord[31:7] == '0) || (sirWord[31:7] == '1));

endmodule

bind sort_intc sort_intc_chk #(.NUM_SRC(NUM_SRC), .SORT_CYCLES(SORT_CYCLES)) chk_i (
  .clk(clk), .rstN(rstN), .irqOut(irqOut), .ackWr(ackWr), .softWr(softWr),
  .strb(strb), .maskVec(maskVec), .sirWord(sirWord)
);

// File: tb/sort_intc_tb_top.sv
`timescale 1ns/1ps
module sort_intc_tb_top;

  localparam int NB = 3;
  localparam int NS = 32 * NB;
  localparam logic [11:0] A_REV = 12'h000, A_CFG = 12'h010, A_STAT = 12'h014,
                          A_SIR = 12'h040, A_CTRL = 12'h048, A_PROT = 12'h04C,
                          A_THR = 12'h068;
  localparam logic [31:0] SPUR = 32'hFFFF_FF80;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [NS-1:0] srcLevel = '0;
  logic irqOut;
  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  sort_intc #(.NUM_BANKS(NB), .SORT_CYCLES(10), .REV_MAJOR(4'h5), .REV_MINOR(4'h0)) dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
    .busRdata(busRdata), .srcLevel(srcLevel), .irqOut(irqOut)
  );

  function automatic logic [11:0] maskA(int b); return 12'(32'h084 + 32 * b); endfunction
  function automatic logic [11:0] clrA(int b);  return 12'(32'h088 + 32 * b); endfunction
  function automatic logic [11:0] setA(int b);  return 12'(32'h08C + 32 * b); endfunction
  function automatic logic [11:0] pendA(int b); return 12'(32'h098 + 32 * b); endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0; busAddr = '0; busWdata = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
    busAddr = '0;
  endtask

  task automatic unmask(input int s);
    wr(clrA(s / 32), 32'h1 << (s % 32));
  endtask

  task automatic cleanup();
    srcLevel = '0;
    for (int b = 0; b < NB; b++) wr(setA(b), 32'hFFFF_FFFF);
    wr(A_CTRL, 32'h1);
    idle(14);
    wr(A_CTRL, 32'h1);
    idle(2);
  endtask

  initial begin
    #4000000;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] lvl, msk;
    idle(3);
    rstN = 1'b1;
    idle(1);

    // R1 reset state
    for (int b = 0; b < NB; b++) begin rd(maskA(b), d); check("R1 mask", d, 32'hFFFF_FFFF); end
    rd(A_SIR, d);  check("R1 sir", d, SPUR);
    rd(A_STAT, d); check("R1 status", d, 32'h1);
    check("R1 irq", {31'b0, irqOut}, 32'h0);

    // R11 revision
    rd(A_REV, d); check("R11 revision", d, 32'h0000_0050);

    // R12 storage registers
    wr(A_PROT, 32'hFFFF_FFFF); wr(A_THR, 32'h0000_01A5); wr(A_CFG, 32'h1);
    rd(A_PROT, d); check("R12 protection", d, 32'h1);
    rd(A_THR, d);  check("R12 threshold", d, 32'hA5);
    rd(A_CFG, d);  check("R12 config", d, 32'h1);

    // R2 mask write paths
    wr(maskA(1), 32'h0F0F_0F0F);
    rd(maskA(1), d); check("R2 direct", d, 32'h0F0F_0F0F);
    wr(clrA(1), 32'h0000_0003);
    rd(maskA(1), d); check("R2 clear", d, 32'h0F0F_0F0C);
    wr(setA(1), 32'h3000_0000);
    rd(maskA(1), d); check("R2 set", d, 32'h3F0F_0F0C);
    wr(clrA(1), 32'h0); wr(setA(1), 32'h0);
    rd(maskA(1), d); check("R2 zero bits", d, 32'h3F0F_0F0C);
    rd(maskA(0), d); check("R2 bank isolation", d, 32'hFFFF_FFFF);
    wr(setA(1), 32'hFFFF_FFFF);

    // R3 pending view
    for (int b = 0; b < NB; b++) srcLevel[b*32 +: 32] = 32'h1234_5678 ^ (32'h1111_1111 * b);
    for (int b = 0; b < NB; b++) wr(maskA(b), ~(32'h00FF_00F0 << b));
    for (int b = 0; b < NB; b++) begin
      lvl = 32'h1234_5678 ^ (32'h1111_1111 * b);
      msk = ~(32'h00FF_00F0 << b);
      rd(pendA(b), d); check("R3 pending", d, lvl & ~msk);
    end
    cleanup();

    // R4 exact latency
    srcLevel[5] = 1'b1;
    unmask(5);
    idle(10); check("R4 not yet", {31'b0, irqOut}, 32'h0);
    idle(1);  check("R4 irq edge", {31'b0, irqOut}, 32'h1);
    rd(A_SIR, d); check("R4 latency sir", d, 32'd5);
    cleanup();

    // R4 sweep over every source
    for (int s = 0; s < NS; s++) begin
      srcLevel[s] = 1'b1;
      unmask(s);
      idle(12);
      rd(A_SIR, d); check("R4 sweep", d, 32'(s));
      srcLevel[s] = 1'b0;
      wr(setA(s / 32), 32'h1 << (s % 32));
      wr(A_CTRL, 32'h1);
      idle(1);
    end

    // R5 lowest wins, pairs across banks
    for (int k = 0; k < 12; k++) begin
      int i, j;
      i = k * 8 + 1;
      j = (k * 37 + 60) % NS;
      if (i != j) begin
        unmask(i); unmask(j);
        idle(1);
        srcLevel[i] = 1'b1; srcLevel[j] = 1'b1;
        idle(13);
        rd(A_SIR, d); check("R5 priority", d, 32'((i < j) ? i : j));
        cleanup();
      end
    end

    // R8 hold and acknowledge, R9 re-sort
    srcLevel[40] = 1'b1; unmask(40); idle(12);
    rd(A_SIR, d); check("R8 first", d, 32'd40);
    srcLevel[2] = 1'b1; unmask(2); idle(5);
    rd(A_SIR, d); check("R8 held sir", d, 32'd40);
    wr(A_CTRL, 32'h0); idle(2);
    check("R8 zero ack ignored", {31'b0, irqOut}, 32'h1);
    wr(A_CTRL, 32'h1); idle(12);
    rd(A_SIR, d); check("R9 next pass", d, 32'd2);
    cleanup();

    // R8 ack during pass ignored
    srcLevel[70] = 1'b1; unmask(70);
    wr(A_CTRL, 32'h1);
    idle(11);
    rd(A_SIR, d); check("R8 ack in pass", d, 32'd70);
    idle(20);
    check("R8 still held", {31'b0, irqOut}, 32'h1);
    cleanup();

    // R6 winner drops and returns
    srcLevel[9] = 1'b1; unmask(9);
    idle(3); srcLevel[9] = 1'b0;
    idle(2); srcLevel[9] = 1'b1;
    idle(10);
    rd(A_SIR, d); check("R6 spurious", d, SPUR);
    check("R6 irq", {31'b0, irqOut}, 32'h1);
    wr(A_CTRL, 32'h1); idle(12);
    rd(A_SIR, d); check("R9 retry", d, 32'd9);
    cleanup();

    // R7 mask change during pass
    srcLevel[20] = 1'b1; srcLevel[40] = 1'b1;
    unmask(20); idle(2); unmask(40); idle(12);
    rd(A_SIR, d); check("R7 change", d, SPUR);
    wr(A_CTRL, 32'h1); idle(12);
    rd(A_SIR, d); check("R7 after retry", d, 32'd20);
    wr(A_CTRL, 32'h1); idle(2);
    wr(setA(1), 32'h1 << (50 - 32));
    idle(12);
    rd(A_SIR, d); check("R7 no change", d, 32'd20);
    cleanup();

    // R10 soft reset
    srcLevel[3] = 1'b1; unmask(3); wr(A_PROT, 32'h1); idle(12);
    check("R10 pre irq", {31'b0, irqOut}, 32'h1);
    wr(A_CFG, 32'h2);
    rd(A_STAT, d); check("R10 busy", d, 32'h0);
    idle(1);
    rd(A_STAT, d); check("R10 done", d, 32'h1);
    rd(maskA(0), d); check("R10 masks", d, 32'hFFFF_FFFF);
    check("R10 irq", {31'b0, irqOut}, 32'h0);
    rd(A_SIR, d); check("R10 sir", d, SPUR);
    rd(A_PROT, d); check("R10 protection", d, 32'h0);
    idle(15);
    check("R10 stays idle", {31'b0, irqOut}, 32'h0);
    srcLevel = '0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule